// File: doc/BRIEF.md
# Floating-Point Compare Exception-Flag Unit

This unit takes two single-precision operands and, instead of a boolean, returns the IEEE exception flags that an ordered greater-than or less-than comparison of them would raise. The flags come back as an integer bit vector, zero-extended to 32 bits. The processor-wide status flags are never touched.

A denormal operand is treated as zero before the comparison, and a dedicated flag bit records that this flush happened. A NaN operand, quiet or signalling, raises the invalid flag, because the comparison is an ordered one. The less-than form is the greater-than form with the two operands exchanged, so both forms give the same flags for the same pair.

A guard word gates the destination write. The flag word and its write strobe are registered and appear one clock after issue.

Top module: `fcmp_flags_unit`

## Requirements
- R1: The result appears exactly one clock after an issue cycle (`op_valid`=1). `res_we` is high for that one cycle only, and only when bit 0 of `guard` was 1 at issue.
- R2: `res_flags` bits 31..7 are always zero. Bits 0..3 are also always zero, and so is bit 6. Those are the divide-by-zero (bit 0), inexact (1), underflow (2), overflow (3) and output-flushed (6) positions.
- R3: If either operand has exponent 0 and a nonzero fraction, bit 5 (input-flushed, 0x20) is set in the result. It is set once even when both operands are denormal.
- R4: If either operand has exponent 0xFF and a nonzero fraction, quiet or signalling, bit 4 (invalid, 0x10) is set in the result.
- R5: Compares of finite numbers, infinities or zeros of either sign give 0x00. Examples: 3.0 vs 0.0, 3.0 vs 3.0, +INF vs -INF, +INF vs +INF.
- R6: The select `op_lt`=1 (less-than, operands swapped) gives the same flag word as `op_lt`=0 for the same operand pair.
- R7: When the guard LSB is 0 at issue, `res_we` stays low and `res_flags` keeps its previous value.
- R8: After reset `res_we` is 0 and `res_flags` is 0.
- R9: A denormal operand together with a NaN gives 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Issue strobe |
| op_lt | input | 1 | 1 = less-than (operands swapped), 0 = greater-than |
| src_a | input | 32 | First operand, single precision |
| src_b | input | 32 | Second operand, single precision |
| guard | input | 32 | Guard word; bit 0 enables the write |
| res_flags | output | 32 | Zero-extended exception flag word |
| res_we | output | 1 | Destination write enable |

## Verification
The in-RTL assertions check on every cycle that:
- the always-zero bit positions stay zero;
- the write strobe follows a guarded issue by exactly one cycle;
- the flag word holds when no write occurs.

Only the bench scenarios show the operand-dependent values:
- flush and invalid detection on specific encodings;
- the single flush bit for double denormals;
- the combined 0x30 case;
- the equality of the swapped form.

The bench does this by comparing every cycle against a behavioural model.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
    localparam int FP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int FLAG_W = 8;

    localparam int B_DBZ = 0;
    localparam int B_INX = 1;
    localparam int B_UNF = 2;
    localparam int B_OVF = 3;
    localparam int B_INV = 4;
    localparam int B_IFZ = 5;
    localparam int B_OFZ = 6;

    typedef struct packed {
        logic is_den;
        logic is_nan;
    } opclass_t;
endpackage

// File: rtl/fcf_classify.sv
module fcf_classify
    import fcf_pkg::*;
#(
    parameter int W  = FP_W,
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [W-1:0] val,
    output opclass_t     cls
);
    localparam logic [EW-1:0] EXP_MAX = {EW{1'b1}};

    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;

    always_comb begin
        exp_f      = val[FW +: EW];
        frac_f     = val[FW-1:0];
        cls.is_den = (exp_f == '0) && (frac_f != '0);
        cls.is_nan = (exp_f == EXP_MAX) && (frac_f != '0);
    end
endmodule

// File: rtl/fcmp_flags_unit.sv
module fcmp_flags_unit
    import fcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_lt,
    input  logic [FP_W-1:0]   src_a,
    input  logic [FP_W-1:0]   src_b,
    input  logic [FP_W-1:0]   guard,
    output logic [FP_W-1:0]   res_flags,
    output logic              res_we
);
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              we;
    } state_t;

    logic [FP_W-1:0] lhs, rhs;
    opclass_t        cls_l, cls_r;
    state_t          st_d, st_q;

    // less-than is greater-than with exchanged operands
    always_comb begin
        lhs = op_lt ? src_b : src_a;
        rhs = op_lt ? src_a : src_b;
    end

    fcf_classify i_cls_l (.val(lhs), .cls(cls_l));
    fcf_classify i_cls_r (.val(rhs), .cls(cls_r));

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (op_valid && guard[0]) begin
            st_d.we    = 1'b1;
            st_d.flags = '0;
            st_d.flags[B_IFZ] = cls_l.is_den | cls_r.is_den;
            st_d.flags[B_INV] = cls_l.is_nan | cls_r.is_nan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_flags = {{(FP_W-FLAG_W){1'b0}}, st_q.flags};
    assign res_we    = st_q.we;

    p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_flags[31:7] == '0) && (res_flags[3:0] == '0) && !res_flags[6]);
    p_we_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && guard[0]) |=> res_we);
    p_no_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && guard[0]) |=> !res_we);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && guard[0]) |=> $stable(res_flags));
endmodule

// File: tb/test_fcmp_flags_unit.sv
module test_fcmp_flags_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        op_valid = 0, op_lt = 0;
    logic [31:0] src_a = 0, src_b = 0, guard = 0;
    logic [31:0] res_flags;
    logic        res_we;

    int checks = 0, failures = 0;
    logic [31:0] exp_flags = 0;
    logic        exp_we = 0;

    fcmp_flags_unit i_fcmp_flags_unit (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
        bit den, nan;
        den = (a[30:23] == 0 && a[22:0] != 0) || (b[30:23] == 0 && b[22:0] != 0);
        nan = (a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0);
        return (den ? 32'h20 : 0) | (nan ? 32'h10 : 0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle, update model, compare mid-cycle after edge
    task automatic issue(input string req, input logic v, input logic lt,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] g);
        op_valid = v; op_lt = lt; src_a = a; src_b = b; guard = g;
        @(posedge clk);
        exp_we = v && g[0];
        if (v && g[0]) exp_flags = model(a, b);
        #(CLK_PERIOD/4);
        check({req, " flags"}, res_flags, exp_flags);
        check({req, " we"}, {31'b0, res_we}, {31'b0, exp_we});
        op_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD*20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*2 + 1);
        check("R8 flags", res_flags, 0);
        check("R8 we", {31'b0, res_we}, 0);
        rst_n = 1;
        @(negedge clk);
        issue("R5 3.0 vs 0.0", 1, 0, 32'h40400000, 32'h0, 1);
        issue("R5 3.0 vs 3.0", 1, 0, 32'h40400000, 32'h40400000, 1);
        issue("R5 inf vs -inf", 1, 0, 32'h7f800000, 32'hff800000, 1);
        issue("R5 inf vs inf", 1, 1, 32'h7f800000, 32'h7f800000, 1);
        issue("R5 signed zeros", 1, 0, 32'h80000000, 32'h0, 1);
        issue("R4 qnan", 1, 0, 32'h40400000, 32'hffffffff, 1);
        issue("R4 snan", 1, 0, 32'h7f800001, 32'h3f800000, 1);
        issue("R3 denormal", 1, 0, 32'h3f800000, 32'h00400000, 1);
        issue("R3 both denormal", 1, 1, 32'h00000001, 32'h807fffff, 1);
        issue("R9 den+nan", 1, 0, 32'h00400000, 32'h7fc00000, 1);
        issue("R6 lt swap nan", 1, 1, 32'h40400000, 32'hffffffff, 1);
        issue("R6 lt swap den", 1, 1, 32'h3f800000, 32'h00400000, 1);
        issue("R7 guard false", 1, 0, 32'h7fc00000, 32'h00400000, 32'hfffffffe);
        issue("R7 idle", 0, 0, 32'h7fc00000, 32'h0, 1);
        issue("R1 write after idle", 1, 0, 32'h40000000, 32'h3f800000, 32'h3);
        issue("R1 strobe drops", 0, 0, 0, 0, 0);
        for (int i = 0; i < 200; i++) begin
            logic [31:0] a, b;
            a = $urandom; b = $urandom;
            if (i % 4 == 0) a[30:23] = 0;
            if (i % 5 == 0) b[30:23] = 8'hFF;
            issue("R2 sweep", 1'($urandom), 1'($urandom), a, b, $urandom);
            check("R2 zero bits", res_flags & 32'hffffffcf, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule